// File: doc/BRIEF.md
# Cascadable Reload Timer Group

Four 8-bit down-counters share one free-running prescaler. Each has its own reload latch. A small register file sets, for each counter, the prescaler ratio, the tick source, a freeze control and how a software write reaches the counter. The tick source can be its own prescaler tap, a neighbour's underflow, or an external clock, so counters can be chained into longer periods.

The second, third and fourth counters drive toggle outputs whose resting level is programmable. The third and fourth can also run as pulse-width generators. Three enables report which outputs have been handed to their pins.

All ticks are synchronous enables on one system clock. The two external clocks are synchronized and their rising edges detected before use. The auxiliary underflow input is a synchronous one-cycle pulse.

Register map. A write at an address changes that register. A read is combinational and returns the register at `addr`.

| Address | Write | Read |
|---|---|---|
| 0 to 3 | reload latch of counter N+1 | live value of counter N+1 |
| 4 | divider codes: [1:0] counter 1, [3:2] counter 2, [5:4] counter 3, [7:6] counter 4 | same |
| 5 | source codes: [1:0] counter 1, [3:2] counter 2, [4] counter 3, [6:5] counter 4 | same, bit 7 reads 0 |
| 6 | [3:0] freeze bits for counters 1 to 4, [6:4] latch-only bits for counters 2 to 4 | same, bit 7 reads 0 |
| 7 | [2:0] start levels for counters 2 to 4, [3] PWM mode of counter 3, [4] PWM mode of counter 4, [7:5] pin enables for counters 2 to 4 | same |
| 8 to 15 | none | 0 |

Top module: `rtg_quad`

## Requirements
- R1: The prescaler code of each counter sets its tick rate against the system clock. Code 01 gives a tick every cycle, 10 a tick every 2 cycles, 00 a tick every 16 cycles and 11 a tick every 256 cycles.
- R2: The source code of counter 1 selects its ticks. 00 is its prescaler tap, 01 is each rising edge of `sub_clk`, 10 is each `aux_uf` pulse, and 11 gives no ticks at all.
- R3: The source code of counter 2 selects its ticks. 00 is each underflow of counter 1, 01 is each rising edge of `sub_clk`, 10 is its prescaler tap, and 11 gives no ticks at all.
- R4: The source bit of counter 3 selects its ticks. 0 is its prescaler tap and 1 is each underflow of counter 2.
- R5: The source code of counter 4 selects its ticks. 00 is its prescaler tap, 01 is each underflow of counter 3, 10 is each underflow of counter 2, and 11 is each rising edge of `main_clk_in`.
- R6: On each tick a counter decrements. A tick that finds it at 0 reloads it from its latch and raises its `uf` bit for exactly one clock. With latch value L this gives one underflow per L+1 ticks. After reset every counter and latch holds 0xFF.
- R7: While a freeze bit is 1 (the reset value), that counter holds its value and gives no underflow. Its output sits at the programmed start level, with 0 meaning low and 1 meaning high.
- R8: A write to counter 1 always loads both its latch and its counter. For counters 2 to 4, a latch-only bit of 0 makes a write load both. A latch-only bit of 1 loads only the latch, and the counter takes the new value at its next underflow.
- R9: In timer mode (PWM bit 0) the output of counters 2 to 4 starts at its start level and inverts on every underflow.
- R10: In PWM mode, counter 3 or 4 holds its output at the start level for L+1 ticks. It then holds the opposite level for 256-L ticks, and repeats.
- R11: `pin_en` mirrors register 7 bits [7:5]. Bit 0 is for counter 2, bit 1 for counter 3 and bit 2 for counter 4.
- R12: Unused register bits and addresses 8 to 15 read as 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 4 | register address for write and read |
| wr_data | input | 8 | write data |
| rd_data | output | 8 | read data at `addr` |
| sub_clk | input | 1 | asynchronous external sub-clock |
| main_clk_in | input | 1 | asynchronous external main clock |
| aux_uf | input | 1 | synchronous underflow pulse from another timer |
| uf | output | 4 | one-cycle underflow pulses, bit N for counter N+1 |
| tout | output | 3 | outputs of counters 2, 3 and 4 |
| pin_en | output | 3 | pin hand-over enables for counters 2, 3 and 4 |

## Verification
The bench builds the block with its default two-stage synchronizer. That setting fixes the latency of the external edges, but the bench measures only intervals between underflows, which do not depend on that latency. Measuring from the second underflow onward removes the partial first period, so every divider code and every chained source can be checked against an exact product of ratios. The longest windows come from the 1/256 tap and from PWM periods of 257 ticks, so random latch values are bounded to keep those runs short.

// File: rtl/rtg_quad.sv
module rtg_quad #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sub_clk,
  input  logic       main_clk_in,
  input  logic       aux_uf,
  output logic [3:0] uf,
  output logic [2:0] tout,
  output logic [2:0] pin_en
);
  localparam int NT = 4;

  logic [7:0] div_r, src_r, run_r, out_r;
  logic [7:0] pc;
  logic [7:0] cnt [NT];
  logic [7:0] lat [NT];
  logic       ufq [NT];
  logic       o   [1:NT-1];
  logic [NT-1:0] pre, tick;
  logic [SYNC_N:0] ss, ms;
  logic sub_e, main_e, s1, s2;

  function automatic logic tap(input logic [1:0] c, input logic [7:0] p);
    case (c)
      2'b00:   tap = (p[3:0] == 4'hF);
      2'b01:   tap = 1'b1;
      2'b10:   tap = p[0];
      default: tap = &p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss <= '0;
      ms <= '0;
      pc <= '0;
    end else begin
      ss <= {ss[SYNC_N-1:0], sub_clk};
      ms <= {ms[SYNC_N-1:0], main_clk_in};
      pc <= pc + 8'd1;
    end
  end

  assign sub_e  = ss[SYNC_N-1] & ~ss[SYNC_N];
  assign main_e = ms[SYNC_N-1] & ~ms[SYNC_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_r <= '0;
      src_r <= '0;
      run_r <= 8'h0F;
      out_r <= '0;
    end else if (wr_en) begin
      case (addr)
        4'd4: div_r <= wr_data;
        4'd5: src_r <= wr_data & 8'h7F;
        4'd6: run_r <= wr_data & 8'h7F;
        4'd7: out_r <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_pre
    assign pre[i] = tap(div_r[2*i +: 2], pc);
  end

  always_comb begin
    case (src_r[1:0])
      2'b00:   s1 = pre[0];
      2'b01:   s1 = sub_e;
      2'b10:   s1 = aux_uf;
      default: s1 = 1'b0;
    endcase
    case (src_r[3:2])
      2'b00:   s2 = ufq[0];
      2'b01:   s2 = sub_e;
      2'b10:   s2 = pre[1];
      default: s2 = 1'b0;
    endcase
  end

  assign tick[0] = s1 & ~run_r[0];
  assign tick[1] = s2 & ~run_r[1];
  assign tick[2] = (src_r[4] ? ufq[1] : pre[2]) & ~run_r[2];
  assign tick[3] = (src_r[6:5] == 2'b00 ? pre[3] :
                    src_r[6:5] == 2'b01 ? ufq[2] :
                    src_r[6:5] == 2'b10 ? ufq[1] : main_e) & ~run_r[3];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic wsel, wlo, go, hit, ph, pwm;
    assign wsel = wr_en && (addr == 4'(i));
    assign wlo  = (i == 0) ? 1'b0 : run_r[3+i];
    assign pwm  = (i >= 2) ? out_r[i+1] : 1'b0;
    assign go   = tick[i] && !(wsel && !wlo);
    assign hit  = go && (cnt[i] == 8'd0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i] <= 8'hFF;
        lat[i] <= 8'hFF;
        ufq[i] <= 1'b0;
      end else begin
        ufq[i] <= hit;
        if (wsel) begin
          lat[i] <= wr_data;
          if (!wlo) cnt[i] <= wr_data;
        end
        if (hit)
          cnt[i] <= (pwm && !ph) ? ~lat[i] : lat[i];
        else if (go)
          cnt[i] <= cnt[i] - 8'd1;
      end
    end

    if (i > 0) begin : g_out
      assign ph = o[i] ^ out_r[i-1];
      always_ff @(posedge clk) begin
        if (!rst_n)         o[i] <= 1'b0;
        else if (run_r[i])  o[i] <= out_r[i-1];
        else if (hit)       o[i] <= ~o[i];
      end
    end else begin : g_noout
      assign ph = 1'b0;
    end
  end

  assign uf     = {ufq[3], ufq[2], ufq[1], ufq[0]};
  assign tout   = {o[3], o[2], o[1]};
  assign pin_en = out_r[7:5];

  always_comb begin
    case (addr)
      4'd0:    rd_data = cnt[0];
      4'd1:    rd_data = cnt[1];
      4'd2:    rd_data = cnt[2];
      4'd3:    rd_data = cnt[3];
      4'd4:    rd_data = div_r;
      4'd5:    rd_data = src_r;
      4'd6:    rd_data = run_r;
      4'd7:    rd_data = out_r;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module rtg_quad_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [3:0] uf,
  input logic [2:0] tout,
  input logic [7:0] run_r,
  input logic [7:0] out_r,
  input logic [7:0] cnt [4]
);
  for (genvar i = 0; i < 4; i++) begin : g_c
    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_r[i] && !(wr_en && addr == 4'(i))) |=> $stable(cnt[i]));
    // R7
    freeze_no_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_r[i]) |-> !uf[i]);
    // R6
    uf_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] |-> ($past(cnt[i]) == 8'd0));
  end
  for (genvar k = 1; k < 4; k++) begin : g_o
    // R7
    rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_r[k] |=> (tout[k-1] == $past(out_r[k-1])));
    // R9
    toggle_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[k] && !$past(run_r[k])) |-> (tout[k-1] != $past(tout[k-1])));
    // R9
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!uf[k] && !$past(run_r[k])) |-> $stable(tout[k-1]));
  end
endmodule

bind rtg_quad rtg_quad_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .uf(uf),
  .tout(tout), .run_r(run_r), .out_r(out_r), .cnt(cnt)
);

// File: tb/rtg_quad_test.sv
`timescale 1ns/1ps
module rtg_quad_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic sub_clk = 0, main_clk_in = 0, aux_uf = 0;
  logic [3:0] uf;
  logic [2:0] tout, pin_en;
  int cyc = 0, nchk = 0, nfail = 0;

  rtg_quad uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .sub_clk(sub_clk),
    .main_clk_in(main_clk_in), .aux_uf(aux_uf), .uf(uf), .tout(tout),
    .pin_en(pin_en));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin repeat (3) @(negedge clk); sub_clk = ~sub_clk; end
  initial forever begin repeat (2) @(negedge clk); main_clk_in = ~main_clk_in; end
  initial forever begin repeat (4) @(negedge clk); aux_uf = 1; @(negedge clk); aux_uf = 0; end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); addr = a; #1 d = int'(rd_data);
  endtask

  task automatic setup(input logic [7:0] l1, l2, l3, l4, dv, sr, ot, rn);
    wr(6, 8'h0F);
    wr(0, l1); wr(1, l2); wr(2, l3); wr(3, l4);
    wr(4, dv); wr(5, sr); wr(7, ot); wr(6, rn);
  endtask

  task automatic wait_uf(input int i, output int t);
    do @(negedge clk); while (!uf[i]);
    t = cyc;
  endtask

  task automatic period(input int i, output int p);
    int t0, t1, t2;
    wait_uf(i, t0); wait_uf(i, t1); wait_uf(i, t2);
    p = t2 - t1;
  endtask

  task automatic wait_lvl(input int k, input logic v, output int t);
    do @(negedge clk); while (tout[k] != v);
    t = cyc;
  endtask

  task automatic level_times(input int k, output int hi, output int lo);
    int a, b, c;
    wait_lvl(k, 1'b0, a); wait_lvl(k, 1'b1, a);
    wait_lvl(k, 1'b0, b); wait_lvl(k, 1'b1, c);
    hi = b - a; lo = c - b;
  endtask

  function automatic int divf(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 1;
      2'b10: return 2;
      default: return 256;
    endcase
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v, a, b, p, hi, lo, n;
    logic [1:0] c1, c4;
    logic [7:0] l1, l4;
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R6 R7 R12 reset state
    for (int i = 0; i < 4; i++) begin rd(4'(i), v); chk("R6 reset counter", v, 255); end
    rd(4, v); chk("R12 reset div", v, 0);
    rd(5, v); chk("R12 reset src", v, 0);
    rd(6, v); chk("R7 reset freeze", v, 15);
    rd(7, v); chk("R12 reset out", v, 0);
    chk("R6 reset uf", int'(uf), 0);
    chk("R7 reset tout", int'(tout), 0);
    chk("R11 reset pin_en", int'(pin_en), 0);

    // R12 unused bits
    wr(5, 8'hFF); rd(5, v); chk("R12 src bit7", v, 8'h7F);
    wr(6, 8'hFF); rd(6, v); chk("R12 run bit7", v, 8'h7F);
    wr(11, 8'hA5); rd(11, v); chk("R12 empty addr", v, 0);
    wr(5, 8'h00); wr(6, 8'h0F);

    // R11
    wr(7, 8'hE0); @(negedge clk); chk("R11 pin all", int'(pin_en), 7);
    wr(7, 8'hA0); @(negedge clk); chk("R11 pin mix", int'(pin_en), 5);
    wr(7, 8'h00);

    // R1 directed
    setup(9, 0, 0, 0, 8'h01, 0, 0, 8'h0E); period(0, p); chk("R1 div1", p, 10);
    @(negedge clk); chk("R6 uf single cycle", int'(uf[0]), 0);
    setup(9, 0, 0, 0, 8'h02, 0, 0, 8'h0E); period(0, p); chk("R1 div2", p, 20);
    setup(9, 0, 0, 0, 8'h00, 0, 0, 8'h0E); period(0, p); chk("R1 div16", p, 160);
    setup(2, 0, 0, 0, 8'h03, 0, 0, 8'h0E); period(0, p); chk("R1 div256", p, 768);

    // R1 R5 R6 random
    for (int it = 0; it < 8; it++) begin
      c1 = 2'($urandom); c4 = 2'($urandom);
      l1 = 8'($urandom % (c1 == 3 ? 3 : c1 == 0 ? 16 : 256));
      l4 = 8'($urandom % (c4 == 3 ? 3 : c4 == 0 ? 16 : 256));
      setup(l1, 0, 0, l4, {c4, 4'b0000, c1}, 0, 0, 8'h06);
      period(0, p); chk("R1 random counter1", p, divf(c1) * (int'(l1) + 1));
      period(3, p); chk("R5 random counter4", p, divf(c4) * (int'(l4) + 1));
    end

    // R2
    setup(2, 0, 0, 0, 8'h55, 8'h01, 0, 8'h0E); period(0, p); chk("R2 sub_clk", p, 18);
    setup(3, 0, 0, 0, 8'h55, 8'h02, 0, 8'h0E); period(0, p); chk("R2 aux_uf", p, 20);
    setup(20, 0, 0, 0, 8'h55, 8'h03, 0, 8'h0E);
    repeat (40) @(negedge clk); rd(0, v); chk("R2 reserved", v, 20);

    // R3
    setup(4, 2, 0, 0, 8'h55, 8'h00, 0, 8'h0C); period(1, p); chk("R3 chain", p, 15);
    setup(0, 1, 0, 0, 8'h55, 8'h04, 0, 8'h0D); period(1, p); chk("R3 sub_clk", p, 12);
    setup(0, 5, 0, 0, 8'hAA, 8'h08, 0, 8'h0D); period(1, p); chk("R3 prescaler", p, 12);
    setup(0, 20, 0, 0, 8'h55, 8'h0C, 0, 8'h0D);
    repeat (40) @(negedge clk); rd(1, v); chk("R3 reserved", v, 20);

    // R4
    setup(0, 3, 4, 0, 8'h55, 8'h18, 0, 8'h09); period(2, p); chk("R4 chain", p, 20);
    setup(0, 0, 6, 0, 8'h20, 8'h00, 0, 8'h0B); period(2, p); chk("R4 prescaler", p, 14);

    // R5
    setup(0, 0, 2, 3, 8'h55, 8'h20, 0, 8'h03); period(3, p); chk("R5 chain3", p, 12);
    setup(0, 1, 0, 4, 8'h55, 8'h48, 0, 8'h05); period(3, p); chk("R5 chain2", p, 10);
    setup(0, 0, 0, 2, 8'h55, 8'h60, 0, 8'h07); period(3, p); chk("R5 main clk", p, 12);

    // R7
    setup(50, 0, 0, 0, 8'h55, 0, 8'h01, 8'h0E);
    repeat (5) @(negedge clk);
    wr(6, 8'h0F); rd(0, a);
    n = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (uf[0]) n++; end
    rd(0, b);
    chk("R7 frozen value", b, a);
    chk("R7 frozen no uf", n, 0);
    chk("R7 rest level high", int'(tout[0]), 1);

    // R8
    setup(0, 0, 0, 0, 8'h55, 8'h08, 0, 8'h0F);
    wr(1, 8'h33); rd(1, v); chk("R8 load both", v, 8'h33);
    wr(6, 8'h1F); wr(1, 8'h05); rd(1, v); chk("R8 latch only", v, 8'h33);
    wr(6, 8'h1D); period(1, p); chk("R8 pickup at underflow", p, 6);
    wr(6, 8'h0F); wr(0, 8'h07); rd(0, v); chk("R8 counter1 always both", v, 7);

    // R9
    setup(0, 3, 0, 0, 8'h55, 8'h08, 8'h00, 8'h0D);
    level_times(0, hi, lo);
    chk("R9 high time", hi, 4); chk("R9 low time", lo, 4);
    setup(0, 3, 0, 0, 8'h55, 8'h08, 8'h01, 8'h0F);
    @(negedge clk); chk("R9 start high", int'(tout[0]), 1);
    wr(6, 8'h0D); @(negedge clk); chk("R9 holds start level", int'(tout[0]), 1);

    // R10
    setup(0, 0, 8'h40, 0, 8'h55, 8'h00, 8'h08, 8'h0B);
    level_times(1, hi, lo);
    chk("R10 pwm away from start", hi, 192); chk("R10 pwm at start", lo, 65);
    setup(0, 0, 8'h40, 0, 8'h55, 8'h00, 8'h0A, 8'h0B);
    level_times(1, hi, lo);
    chk("R10 pwm start high", hi, 65); chk("R10 pwm low phase", lo, 192);
    l4 = 8'(1 + $urandom % 254);
    setup(0, 0, 0, l4, 8'h55, 8'h00, 8'h10, 8'h07);
    level_times(2, hi, lo);
    chk("R10 pwm counter4 high", hi, 256 - int'(l4));
    chk("R10 pwm counter4 low", lo, int'(l4) + 1);

    summary();
    $finish;
  end
endmodule